// File: doc/BRIEF.md
# E1 Timeslot-0 Odd-Frame Byte Generator

This block produces the 8-bit timeslot-0 value sent in the odd (non-frame-alignment) frames of a 2048 kbit/s E1 link. On each timeslot-0 strobe of an odd frame it assembles a new byte from the configuration bits, the position within the 16-frame CRC multiframe, and two held CRC results. Its output is a parallel byte, MSB first in transmit order, which a later stage serializes.

The first transmitted bit has several sources. With CRC generation off it is the international-use bit. With CRC on, frames 1 to 11 carry the multiframe alignment pattern. Frames 13 and 15 carry either the international-use bit or, with Si-multiplexing on, the result of the CRC check for submultiframe I or II. Each CRC result is captured when its valid strobe arrives and held until it is transmitted.

The byte leaves on a valid/ready pair. `out_valid` rises one cycle after each update and stays high until a cycle with `out_ready` high accepts it. Back-pressure cannot stall the line: the byte stays stable while `out_valid` waits, and the next odd-frame strobe overwrites it whether or not it was taken.

Top module: `e1_nfas_gen`

## Requirements
- R1: After reset, `ts0_byte` is 8'hDF (bit 1 = 1, NFAS bit = 1, alarm = 0, national bits all 1) and `out_valid` is 0.
- R2: `ts0_byte` changes only at a rising edge where `ts0_stb` = 1 and `frame_num[0]` = 1 (an update). A strobe in an even frame leaves the byte and `out_valid` unchanged.
- R3: After an update, `ts0_byte[6]` (transmit position 2) equals `cfg_nfas` and `ts0_byte[5]` (position 3) equals `cfg_alarm`.
- R4: After an update, `ts0_byte[4:0]` (positions 4 to 8) equals `cfg_natl`, with `cfg_natl[4]` (NU1) in position 4.
- R5: With `cfg_crc_en` = 0, `ts0_byte[7]` (position 1) equals `cfg_intl` in every odd frame, whatever `cfg_simux_en` is.
- R6: With `cfg_crc_en` = 1, position 1 in frames 1, 3, 5, 7, 9, 11 is 0, 0, 1, 0, 1, 1 respectively.
- R7: With `cfg_crc_en` = 1 and `cfg_simux_en` = 0, position 1 in frames 13 and 15 equals `cfg_intl`.
- R8: With `cfg_crc_en` = 1 and `cfg_simux_en` = 1, position 1 in frame 13 is the held submultiframe I result and in frame 15 the held submultiframe II result. `cfg_intl` has no effect.
- R9: A CRC result input is captured only in a cycle where its valid input is 1. Both held results reset to 1. Changes on `sm1_crc_ok` or `sm2_crc_ok` without a valid have no effect.
- R10: `out_valid` is 1 in the cycle after each update and stays 1 until a cycle with `out_ready` = 1. `out_ready` never affects `ts0_byte`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_num | input | 4 | Frame index within the CRC multiframe (0..15) |
| ts0_stb | input | 1 | One-cycle strobe at each timeslot-0 slot |
| cfg_intl | input | 1 | International-use bit |
| cfg_nfas | input | 1 | Non-frame-alignment indicator bit |
| cfg_alarm | input | 1 | Remote alarm bit |
| cfg_natl | input | 5 | National-use bits, [4] = NU1 |
| cfg_crc_en | input | 1 | CRC multiframe operation enable |
| cfg_simux_en | input | 1 | Insert CRC results in frames 13/15 |
| sm1_crc_ok | input | 1 | Submultiframe I CRC result |
| sm1_crc_vld | input | 1 | Capture strobe for `sm1_crc_ok` |
| sm2_crc_ok | input | 1 | Submultiframe II CRC result |
| sm2_crc_vld | input | 1 | Capture strobe for `sm2_crc_ok` |
| out_ready | input | 1 | Downstream accepts the byte |
| ts0_byte | output | 8 | Timeslot-0 byte, [7] sent first |
| out_valid | output | 1 | New byte pending |

## Verification
The assertions assume the configuration inputs are steady across the update edge. They also assume that `frame_num` does not change in a cycle where `ts0_stb` is high, so that the sampled frame index names the frame being sent. The stimulus changes configuration and frame index only at falling edges. It pulses the strobe once per frame and walks the frames in order through whole multiframes. It delivers CRC results on their own strobes well away from frames 13 and 15.

// File: rtl/e1_nfas_pkg.sv
package e1_nfas_pkg;
  localparam int FRAME_W  = 4;
  localparam int NAT_W    = 5;
  localparam int BYTE_W   = 3 + NAT_W;
  localparam int MFAS_LEN = 6;
  // alignment pattern, element 0 first: 0,0,1,0,1,1
  localparam logic [MFAS_LEN-1:0] MFAS_PAT = 6'b110100;

  typedef struct packed {
    logic             nfas;
    logic             alarm;
    logic [NAT_W-1:0] natl;
  } fixed_fields_t;
endpackage

// File: rtl/e1_crc_hold.sv
module e1_crc_hold #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic res,
  input  logic vld,
  output logic held
);
  always_ff @(posedge clk) begin
    if (!rst_n)   held <= RST_VAL;
    else if (vld) held <= res;
  end
endmodule

// File: rtl/e1_bit1_sel.sv
module e1_bit1_sel
  import e1_nfas_pkg::*;
#(
  parameter int FW = FRAME_W
) (
  input  logic          [FW-1:0] frame_num,
  input  logic                   crc_en,
  input  logic                   simux_en,
  input  logic                   intl,
  input  logic          [1:0]    sm_held,
  output logic                   bit1
);
  localparam int NSLOT = 1 << (FW - 1);
  localparam logic [FW-1:0] SM1_FRAME = FW'((1 << FW) - 3);
  localparam logic [FW-1:0] SM2_FRAME = FW'((1 << FW) - 1);

  logic [NSLOT-1:0] mfas_vec;

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    if (i < MFAS_LEN) begin : g_pat
      assign mfas_vec[i] = MFAS_PAT[i];
    end else begin : g_spare
      assign mfas_vec[i] = 1'b1;
    end
  end

  always_comb begin
    if (!crc_en) begin
      bit1 = intl;
    end else if (frame_num == SM1_FRAME) begin
      bit1 = simux_en ? sm_held[0] : intl;
    end else if (frame_num == SM2_FRAME) begin
      bit1 = simux_en ? sm_held[1] : intl;
    end else begin
      bit1 = mfas_vec[frame_num[FW-1:1]];
    end
  end
endmodule

// File: rtl/e1_ts0_reg.sv
module e1_ts0_reg #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_BYTE = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] next_byte,
  input  logic         out_ready,
  output logic [W-1:0] ts0_byte,
  output logic         out_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ts0_byte  <= RST_BYTE;
      out_valid <= 1'b0;
    end else begin
      if (load) ts0_byte <= next_byte;
      if (load)           out_valid <= 1'b1;
      else if (out_ready) out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/e1_nfas_gen.sv
module e1_nfas_gen
  import e1_nfas_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [FRAME_W-1:0] frame_num,
  input  logic               ts0_stb,
  input  logic               cfg_intl,
  input  logic               cfg_nfas,
  input  logic               cfg_alarm,
  input  logic [NAT_W-1:0]   cfg_natl,
  input  logic               cfg_crc_en,
  input  logic               cfg_simux_en,
  input  logic               sm1_crc_ok,
  input  logic               sm1_crc_vld,
  input  logic               sm2_crc_ok,
  input  logic               sm2_crc_vld,
  input  logic               out_ready,
  output logic [BYTE_W-1:0]  ts0_byte,
  output logic               out_valid
);
  // reset byte: spare bits 1, alarm 0
  localparam logic [BYTE_W-1:0] RST_BYTE = ~(BYTE_W'(1) << NAT_W);

  logic [1:0]        sm_res, sm_vld, sm_held;
  logic              bit1;
  logic              load;
  fixed_fields_t     fixed;
  logic [BYTE_W-1:0] next_byte;

  assign sm_res = {sm2_crc_ok, sm1_crc_ok};
  assign sm_vld = {sm2_crc_vld, sm1_crc_vld};

  for (genvar g = 0; g < 2; g++) begin : g_hold
    e1_crc_hold #(.RST_VAL(1'b1)) u_hold (
      .clk  (clk),
      .rst_n(rst_n),
      .res  (sm_res[g]),
      .vld  (sm_vld[g]),
      .held (sm_held[g])
    );
  end

  e1_bit1_sel #(.FW(FRAME_W)) u_sel (
    .frame_num(frame_num),
    .crc_en   (cfg_crc_en),
    .simux_en (cfg_simux_en),
    .intl     (cfg_intl),
    .sm_held  (sm_held),
    .bit1     (bit1)
  );

  assign fixed     = '{nfas: cfg_nfas, alarm: cfg_alarm, natl: cfg_natl};
  assign next_byte = {bit1, fixed};
  assign load      = ts0_stb & frame_num[0];

  e1_ts0_reg #(.W(BYTE_W), .RST_BYTE(RST_BYTE)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .next_byte(next_byte),
    .out_ready(out_ready),
    .ts0_byte (ts0_byte),
    .out_valid(out_valid)
  );
endmodule

// File: rtl/e1_nfas_chk.sv
module e1_nfas_chk
  import e1_nfas_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [FRAME_W-1:0] frame_num,
  input logic               ts0_stb,
  input logic               cfg_intl,
  input logic               cfg_nfas,
  input logic               cfg_alarm,
  input logic [NAT_W-1:0]   cfg_natl,
  input logic               cfg_crc_en,
  input logic               cfg_simux_en,
  input logic               sm1_crc_ok,
  input logic               sm1_crc_vld,
  input logic               sm2_crc_ok,
  input logic               sm2_crc_vld,
  input logic               out_ready,
  input logic [BYTE_W-1:0]  ts0_byte,
  input logic               out_valid
);
  localparam logic [FRAME_W-1:0] F1  = FRAME_W'(1);
  localparam logic [FRAME_W-1:0] F5  = FRAME_W'(5);
  localparam logic [FRAME_W-1:0] F13 = FRAME_W'((1 << FRAME_W) - 3);
  localparam logic [FRAME_W-1:0] F15 = FRAME_W'((1 << FRAME_W) - 1);

  logic upd, sh1, sh2;
  assign upd = ts0_stb && frame_num[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh1 <= 1'b1;
      sh2 <= 1'b1;
    end else begin
      if (sm1_crc_vld) sh1 <= sm1_crc_ok;
      if (sm2_crc_vld) sh2 <= sm2_crc_ok;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ts0_stb |=> $stable(ts0_byte)); // R2
  AST_EVEN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ts0_stb && !frame_num[0]) |=> $stable(ts0_byte)); // R2
  AST_NFAS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> (ts0_byte[6] == $past(cfg_nfas)) && (ts0_byte[5] == $past(cfg_alarm))); // R3
  AST_NATL: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> ts0_byte[4:0] == $past(cfg_natl)); // R4
  AST_NOCRC_INTL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !cfg_crc_en) |=> ts0_byte[7] == $past(cfg_intl)); // R5
  AST_MFAS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_crc_en && frame_num == F1) |=> !ts0_byte[7]); // R6
  AST_MFAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_crc_en && frame_num == F5) |=> ts0_byte[7]); // R6
  AST_SM_INTL: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_crc_en && !cfg_simux_en && (frame_num == F13 || frame_num == F15))
      |=> ts0_byte[7] == $past(cfg_intl)); // R7
  AST_SM1_INS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_crc_en && cfg_simux_en && frame_num == F13) |=> ts0_byte[7] == $past(sh1)); // R8
  AST_SM2_INS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && cfg_crc_en && cfg_simux_en && frame_num == F15) |=> ts0_byte[7] == $past(sh2)); // R8
  AST_VALID_SET: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> out_valid); // R10
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && out_ready) |=> !out_valid); // R10
endmodule

bind e1_nfas_gen e1_nfas_chk u_chk (.*);

// File: tb/tb_e1_nfas_gen.sv
`timescale 1ns/1ps
module tb_e1_nfas_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] frame_num = '0;
  logic       ts0_stb = 1'b0;
  logic       cfg_intl = 1'b1, cfg_nfas = 1'b1, cfg_alarm = 1'b0;
  logic [4:0] cfg_natl = 5'h1F;
  logic       cfg_crc_en = 1'b0, cfg_simux_en = 1'b0;
  logic       sm1_crc_ok = 1'b0, sm1_crc_vld = 1'b0;
  logic       sm2_crc_ok = 1'b0, sm2_crc_vld = 1'b0;
  logic       out_ready = 1'b1;
  logic [7:0] ts0_byte;
  logic       out_valid;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic m_sm1 = 1'b1, m_sm2 = 1'b1;
  logic [7:0] last_exp = 8'hDF;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  e1_nfas_gen dut (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_bit1(input int fn);
    if (!cfg_crc_en) return cfg_intl;
    if (fn == 13) return cfg_simux_en ? m_sm1 : cfg_intl;
    if (fn == 15) return cfg_simux_en ? m_sm2 : cfg_intl;
    case (fn)
      1, 3, 7: return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic string model_tag(input int fn);
    if (!cfg_crc_en) return "R5/R3/R4";
    if (fn <= 11) return "R6";
    if (cfg_simux_en) return "R8/R9";
    return "R7";
  endfunction

  task automatic drive_frame(input int fn);
    @(negedge clk);
    frame_num = 4'(fn);
    ts0_stb = 1'b1;
    if (fn % 2 == 1) begin
      last_exp = {model_bit1(fn), cfg_nfas, cfg_alarm, cfg_natl};
      exp_q.push_back(last_exp);
      tag_q.push_back(model_tag(fn));
    end
    @(negedge clk);
    ts0_stb = 1'b0;
    if (fn % 2 == 0) begin
      check("R2 even byte", ts0_byte, last_exp);
      check("R2 even valid", {7'd0, out_valid}, 8'd0);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic run_mf();
    for (int f = 0; f < 16; f++) drive_frame(f);
  endtask

  task automatic send_crc(input int which, input logic v);
    @(negedge clk);
    if (which == 1) begin sm1_crc_ok = v; sm1_crc_vld = 1'b1; m_sm1 = v; end
    else            begin sm2_crc_ok = v; sm2_crc_vld = 1'b1; m_sm2 = v; end
    @(negedge clk);
    sm1_crc_vld = 1'b0;
    sm2_crc_vld = 1'b0;
  endtask

  // monitor: pops expected bytes as the design offers them
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R10: unexpected byte %h, expected none", ts0_byte);
      end else begin
        check(tag_q.pop_front(), ts0_byte, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset byte", ts0_byte, 8'hDF);
    check("R1 reset valid", {7'd0, out_valid}, 8'd0);

    run_mf();  // defaults, CRC off

    cfg_intl = 1'b0; cfg_alarm = 1'b1; cfg_natl = 5'b10110; cfg_simux_en = 1'b1;
    run_mf();  // R5 with simux on but CRC off

    cfg_crc_en = 1'b1; cfg_simux_en = 1'b0; cfg_natl = 5'b01001; cfg_alarm = 1'b0;
    run_mf();  // R6, R7 with intl = 0

    cfg_simux_en = 1'b1; cfg_intl = 1'b1;
    send_crc(1, 1'b0);
    send_crc(2, 1'b1);
    @(negedge clk);
    sm1_crc_ok = 1'b1; sm2_crc_ok = 1'b0;  // no valid: must be ignored (R9)
    run_mf();  // R8

    cfg_intl = 1'b0;
    send_crc(1, 1'b1);
    send_crc(2, 1'b0);
    run_mf();

    // back-pressure: R10
    @(posedge clk); #1 out_ready = 1'b0;
    drive_frame(3);
    repeat (3) @(negedge clk);
    check("R10 valid held", {7'd0, out_valid}, 8'd1);
    check("R10 byte stable", ts0_byte, last_exp);
    @(posedge clk); #1 out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 valid dropped", {7'd0, out_valid}, 8'd0);
    check("R10 queue drained", 8'(exp_q.size()), 8'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule